// File: doc/BRIEF.md
# 32-Pin General-Purpose I/O Port

This block is a bank of general-purpose pins behind a simple word-addressed register bus. Each pin has an output level and a direction. It also has a per-pin setup word that chooses the direction, whether the input path sees the pad, and an optional pull. Each pin faces an external driver that can hold the pad at 0 or 1, or release it. The port drives its output level and output enable toward the pad and records the level it senses in an input register. Software changes the output and direction bits either by whole-word writes or through set and clear aliases. Those aliases change only the bits written as 1.

The direction bit has a single store. The whole-word direction register, its aliases and bit 0 of every pin setup word all read and write that same bit. When nothing drives a pin, the sensed level comes from the pin's own output (if it is an output with its input connected) or from the selected pull. With neither, the sensed level holds its last value. If a pin drives one level while an outside source drives the other, the port raises a sticky error flag. Software clears the flag by writing to a status word.

Top module: `gpio_port`

## Requirements
- R1: The word map, by word address, is: 0 output level, 1 output set, 2 output clear, 3 sensed input, 4 direction, 5 direction set, 6 direction clear, 7 status (bit 0 = error flag), and 32+i the setup word of pin i. After reset, words 0 to 7 read 0, pad_oe and pad_out are 0, and short_err is 0.
- R2: After reset, every pin setup word reads 0x00000002: input, with the input path disconnected and no pull.
- R3: A write to word 4 loads all direction bits, and a write to word 5 sets the bits written as 1. Bit 0 of each affected setup word reads the new direction (1 = output).
- R4: A write to word 6 clears the direction bits written as 1, both in word 4 and in bit 0 of the matching setup words.
- R5: In a setup word, bit 0 is the direction, bit 1 = 1 disconnects the input path, and bits 3:2 select the pull (01 = pull-down, 11 = pull-up, others = none). Writing a setup word also updates that pin's bit in word 4. Bits 31:4 read 0.
- R6: With the input path connected and no pull, the sensed bit takes the external level one clock after it is applied, and keeps it when the driver releases the pin.
- R7: When the pin is not both connected and externally driven, and is not a connected output, pull-up makes the sensed bit 1 and pull-down makes it 0. A disconnected input path ignores the external driver.
- R8: Word 0 loads the output bits, word 1 sets the bits written as 1, and word 2 clears them. pad_out shows the output bits and pad_oe shows the direction bits.
- R9: An output pin with its input path connected and no external drive senses its own output level.
- R10: An output pin whose external driver holds the opposite level sets short_err on the next clock. The flag stays set until word 7 is written. A short that is present in the same cycle as that write wins over the clear. Word 7 bit 0 reads the flag.
- R11: Writes to word 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write strobe for the word at bus_addr |
| bus_addr | input | ADDR_W | Word address for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ext_en | input | N_PINS | 1 where an outside source drives the pin |
| ext_val | input | N_PINS | Level driven by the outside source |
| pad_out | output | N_PINS | Output level toward the pad |
| pad_oe | output | N_PINS | Output enable toward the pad |
| short_err | output | 1 | Sticky contention flag |

## Verification
The bench goes after three sharp corners. First, the direction bit is reached from four places. A design that kept a separate copy per setup word would show pin 31 still as an output after a direction clear. Second, a released pin must hold its level. A design that falls back to 0 would lose a sensed 1. The bench also drives a disconnected pin against its pull, so a design that lets the external driver through would read the driven level instead of the pull. Third, contention on the error flag: a design that let a clear win over a short in the same cycle would drop a real fault. A design that flagged matching levels, or driven inputs, would report false faults.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_PINS-1:0] ext_en,
  input  logic [N_PINS-1:0] ext_val,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_oe,
  output logic              short_err
);
  localparam int IDX_W = (N_PINS > 1) ? $clog2(N_PINS) : 1;
  localparam logic [ADDR_W-1:0] W_OUT = 0, W_OSET = 1, W_OCLR = 2, W_IN = 3,
                                W_DIR = 4, W_DSET = 5, W_DCLR = 6, W_STAT = 7,
                                W_CFG = 32;

  logic [N_PINS-1:0]      out_q, dir_q, in_q, sense_d;
  logic [N_PINS-1:0][2:0] cfg_q;
  logic                   err_q;
  logic [N_PINS-1:0]      wmask;
  logic [ADDR_W-1:0]      cfg_off;
  logic                   cfg_hit;
  logic [IDX_W-1:0]       idx;
  logic                   shorted;

  assign wmask   = bus_wdata[N_PINS-1:0];
  assign cfg_off = bus_addr - W_CFG;
  assign cfg_hit = (bus_addr >= W_CFG) && (cfg_off < ADDR_W'(N_PINS));
  assign idx     = cfg_off[IDX_W-1:0];

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    logic conn;
    logic [1:0] pull;
    assign conn = ~cfg_q[i][0];
    assign pull = cfg_q[i][2:1];
    always_comb begin
      if (conn && ext_en[i])      sense_d[i] = ext_val[i];
      else if (conn && dir_q[i])  sense_d[i] = out_q[i];
      else if (pull == 2'b11)     sense_d[i] = 1'b1;
      else if (pull == 2'b01)     sense_d[i] = 1'b0;
      else                        sense_d[i] = in_q[i];
    end
  end

  assign shorted = |(dir_q & ext_en & (ext_val ^ out_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      dir_q <= '0;
      in_q  <= '0;
      err_q <= 1'b0;
      for (int i = 0; i < N_PINS; i++) cfg_q[i] <= 3'b001;
    end else begin
      in_q  <= sense_d;
      err_q <= shorted | (err_q & ~(bus_we && bus_addr == W_STAT));
      if (bus_we) begin
        case (bus_addr)
          W_OUT:  out_q <= wmask;
          W_OSET: out_q <= out_q | wmask;
          W_OCLR: out_q <= out_q & ~wmask;
          W_DIR:  dir_q <= wmask;
          W_DSET: dir_q <= dir_q | wmask;
          W_DCLR: dir_q <= dir_q & ~wmask;
          default: if (cfg_hit) begin
            cfg_q[idx] <= bus_wdata[3:1];
            dir_q[idx] <= bus_wdata[0];
          end
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      W_OUT, W_OSET, W_OCLR: bus_rdata = 32'(out_q);
      W_IN:                  bus_rdata = 32'(in_q);
      W_DIR, W_DSET, W_DCLR: bus_rdata = 32'(dir_q);
      W_STAT:                bus_rdata = {31'b0, err_q};
      default: if (cfg_hit)  bus_rdata = {28'b0, cfg_q[idx], dir_q[idx]};
    endcase
  end

  assign pad_out   = out_q;
  assign pad_oe    = dir_q;
  assign short_err = err_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [N_PINS-1:0] ext_en,
  input logic [N_PINS-1:0] ext_val,
  input logic [N_PINS-1:0] pad_out,
  input logic [N_PINS-1:0] pad_oe,
  input logic              short_err
);
  localparam logic [ADDR_W-1:0] W_OSET = 1, W_OCLR = 2, W_DSET = 5,
                                W_DCLR = 6, W_STAT = 7;

  a_r3_dirset_raises: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == W_DSET) |=>
      ((pad_oe & $past(bus_wdata[N_PINS-1:0])) == $past(bus_wdata[N_PINS-1:0])));

  a_r4_dirclr_drops: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == W_DCLR) |=> ((pad_oe & $past(bus_wdata[N_PINS-1:0])) == '0));

  a_r8_outset_raises: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == W_OSET) |=>
      ((pad_out & $past(bus_wdata[N_PINS-1:0])) == $past(bus_wdata[N_PINS-1:0])));

  a_r8_outclr_drops: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == W_OCLR) |=> ((pad_out & $past(bus_wdata[N_PINS-1:0])) == '0));

  a_r10_short_flags: assert property (@(posedge clk) disable iff (rst)
    (|(pad_oe & ext_en & (ext_val ^ pad_out))) |=> short_err);

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (short_err && !(bus_we && bus_addr == W_STAT)) |=> short_err);

  a_r10_no_false_flag: assert property (@(posedge clk) disable iff (rst)
    $rose(short_err) |-> $past(|(pad_oe & ext_en & (ext_val ^ pad_out))));
endmodule

bind gpio_port gpio_port_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ext_en(ext_en), .ext_val(ext_val),
  .pad_out(pad_out), .pad_oe(pad_oe), .short_err(short_err)
);

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
  localparam int N = 32;
  localparam int AW = 7;

  logic clk = 1'b0, rst = 1'b1, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] ext_en = '0, ext_val = '0, pad_out, pad_oe;
  logic short_err;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_port #(.N_PINS(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_en(ext_en),
    .ext_val(ext_val), .pad_out(pad_out), .pad_oe(pad_oe), .short_err(short_err)
  );

  typedef struct packed {
    logic we; logic [6:0] wa; logic [31:0] wd;
    logic [31:0] xen; logic [31:0] xval;
    logic [6:0] ra; logic [31:0] exp; logic [3:0] req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 7'd5,  32'h80000001, 32'h0, 32'h0, 7'd4,  32'h80000001, 4'd3}, // R3 dirset
    '{1'b0, 7'd0,  32'h0,        32'h0, 32'h0, 7'd32, 32'h3,        4'd3}, // R3 cfg0 follows
    '{1'b0, 7'd0,  32'h0,        32'h0, 32'h0, 7'd63, 32'h3,        4'd3}, // R3 cfg31 follows
    '{1'b1, 7'd6,  32'h80000001, 32'h0, 32'h0, 7'd4,  32'h0,        4'd4}, // R4 dirclr
    '{1'b0, 7'd0,  32'h0,        32'h0, 32'h0, 7'd63, 32'h2,        4'd4}, // R4 cfg31 cleared
    '{1'b1, 7'd4,  32'h80000001, 32'h0, 32'h0, 7'd4,  32'h80000001, 4'd3}, // R3 whole write
    '{1'b1, 7'd63, 32'h2,        32'h0, 32'h0, 7'd4,  32'h1,        4'd5}, // R5 cfg -> dir
    '{1'b1, 7'd4,  32'h0,        32'h0, 32'h0, 7'd32, 32'h2,        4'd5}, // R5 dir -> cfg
    '{1'b1, 7'd32, 32'h0,        32'h1, 32'h0, 7'd3,  32'h0,        4'd6}, // R6 drive 0
    '{1'b0, 7'd0,  32'h0,        32'h1, 32'h1, 7'd3,  32'h1,        4'd6}, // R6 drive 1
    '{1'b0, 7'd0,  32'h0,        32'h0, 32'h0, 7'd3,  32'h1,        4'd6}, // R6 hold
    '{1'b1, 7'd32, 32'hE,        32'h1, 32'h0, 7'd3,  32'h1,        4'd7}, // R7 pull-up
    '{1'b1, 7'd32, 32'h6,        32'h1, 32'h1, 7'd3,  32'h0,        4'd7}, // R7 pull-down
    '{1'b1, 7'd32, 32'h3,        32'h0, 32'h0, 7'd0,  32'h0,        4'd8}, // R8 out idle
    '{1'b1, 7'd1,  32'h1,        32'h0, 32'h0, 7'd0,  32'h1,        4'd8}, // R8 outset
    '{1'b1, 7'd2,  32'h1,        32'h0, 32'h0, 7'd0,  32'h0,        4'd8}, // R8 outclr
    '{1'b1, 7'd32, 32'h1,        32'h0, 32'h0, 7'd3,  32'h0,        4'd9}, // R9 loop low
    '{1'b1, 7'd1,  32'h1,        32'h0, 32'h0, 7'd3,  32'h1,        4'd9}, // R9 loop high
    '{1'b1, 7'd2,  32'h1,        32'h0, 32'h0, 7'd3,  32'h0,        4'd9}, // R9 loop low
    '{1'b1, 7'd3,  32'hFFFFFFFF, 32'h0, 32'h0, 7'd3,  32'h0,        4'd11},// R11 in read-only
    '{1'b0, 7'd0,  32'h0,        32'h0, 32'h0, 7'd7,  32'h0,        4'd10},// R10 no flag yet
    '{1'b1, 7'd0,  32'h100,      32'h0, 32'h0, 7'd0,  32'h100,      4'd8}, // R8 whole out
    '{1'b1, 7'd2,  32'h100,      32'h0, 32'h0, 7'd0,  32'h0,        4'd8}  // R8 outclr
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [6:0] a, input string req, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1 check(req, bus_rdata, exp);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int a = 0; a < 8; a++) rd(7'(a), "R1", 32'h0);
    for (int p = 0; p < N; p++) rd(7'(32 + p), "R2", 32'h2);
    check("R1", 32'(pad_oe), 32'h0);
    check("R1", 32'(pad_out), 32'h0);
    check("R1", {31'b0, short_err}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      ext_en = VEC[v].xen; ext_val = VEC[v].xval;
      bus_we = VEC[v].we; bus_addr = VEC[v].wa; bus_wdata = VEC[v].wd;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = VEC[v].ra;
      @(negedge clk);
      #1 check($sformatf("R%0d vec%0d", VEC[v].req, v), bus_rdata, VEC[v].exp);
    end

    wr(7'd0, 32'hA5A5A5A5);
    #1 check("R8 pad_out", 32'(pad_out), 32'hA5A5A5A5);
    check("R8 pad_oe", 32'(pad_oe), 32'h1);
    wr(7'd0, 32'h0);

    @(negedge clk); ext_en = 32'h1; ext_val = 32'h1;
    @(negedge clk); #1 check("R10 short sets", {31'b0, short_err}, 32'h1);
    ext_en = '0;
    repeat (3) @(negedge clk);
    #1 check("R10 sticky", {31'b0, short_err}, 32'h1);
    rd(7'd7, "R10 status read", 32'h1);
    wr(7'd7, 32'h0);
    #1 check("R10 cleared", {31'b0, short_err}, 32'h0);
    @(negedge clk); ext_en = 32'h1; ext_val = 32'h0;
    @(negedge clk); #1 check("R10 same level", {31'b0, short_err}, 32'h0);
    ext_en = 32'h20; ext_val = 32'h20;
    @(negedge clk); #1 check("R10 input pin", {31'b0, short_err}, 32'h0);
    ext_en = 32'h1; ext_val = 32'h1;
    bus_we = 1'b1; bus_addr = 7'd7;
    @(negedge clk); bus_we = 1'b0; ext_en = '0;
    #1 check("R10 set beats clear", {31'b0, short_err}, 32'h1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule